// File: doc/BRIEF.md
# Ordered Instruction Breakpoint Table

This block keeps a short, ordered list of instruction breakpoints. Each slot pairs a 32-bit instruction address with a 2-bit breakpoint kind. A debug controller adds breakpoints and removes them by request. The fetch side presents its program counter every cycle and reads back, combinationally, the kind of the earliest slot whose address matches.

Removal finds the first slot whose address and kind both match. It then closes the gap by moving every later slot down one position, one slot per clock, so the list keeps its order. While the block is moving slots, `busy_o` is high and the block ignores new requests. Each change to the table sends a one-cycle invalidate pulse that carries the affected address. A decode cache can use this pulse to drop its copy of that instruction word.

Top module: `bkpt_table`

## Requirements
- R1: When the block is idle and the table is not full, an add with a nonzero kind stores the entry at index `count_o`. `count_o` is one higher on the following cycle.
- R2: An add while `count_o` equals DEPTH (default 8) leaves the table unchanged and raises `ovf_o` for exactly one cycle, on the cycle after the request.
- R3: An add whose kind is 0 is ignored. The table, the count, the invalidate output and the overflow flag stay unchanged, because kind 0 is reserved to mean "no breakpoint".
- R4: An accepted remove acts on the lowest-index entry whose address and kind both equal the request. On the next cycle `rem_done_o` and `rem_hit_o` are both 1.
- R5: A remove that matches no entry gives `rem_done_o`=1 and `rem_hit_o`=0 on the next cycle. The table and the count stay unchanged and no invalidate is sent.
- R6: When a remove hits index i of n entries, the later entries keep their order. `busy_o` is high for n-1-i cycles and `count_o` drops by one on the cycle `busy_o` falls. When i is n-1, `count_o` drops on the next cycle and `busy_o` stays low.
- R7: Add and remove requests that arrive while `busy_o` is high are ignored.
- R8: When add and remove are requested in the same idle cycle, only the remove is performed. The add is dropped.
- R9: `pc_type_o` is the kind of the lowest-index valid entry whose address equals `pc_i`, or 0 if no entry matches. This also holds during compaction.
- R10: One cycle after an accepted add, or after a remove that hits, `inv_vld_o` is 1 for one cycle and `inv_addr_o` holds that request's address.
- R11: After reset the table is empty, and `count_o`, `busy_o`, `inv_vld_o`, `rem_done_o`, `rem_hit_o`, `ovf_o` and `pc_type_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| add_vld_i | input | 1 | Add request |
| add_addr_i | input | 32 | Address to add |
| add_type_i | input | 2 | Kind to add (0 reserved) |
| rem_vld_i | input | 1 | Remove request |
| rem_addr_i | input | 32 | Address to remove |
| rem_type_i | input | 2 | Kind to remove |
| rem_done_o | output | 1 | Remove finished its search |
| rem_hit_o | output | 1 | Remove found a matching entry |
| pc_i | input | 32 | Program counter to look up |
| pc_type_o | output | 2 | Kind of the first matching entry, 0 if none |
| count_o | output | 4 | Number of valid entries |
| busy_o | output | 1 | Compaction in progress; requests ignored |
| ovf_o | output | 1 | An add was refused because the table was full |
| inv_vld_o | output | 1 | Invalidate pulse |
| inv_addr_o | output | 32 | Address to invalidate |

## Verification
Two things can happen in the same cycle: a lookup and a compaction that is still running. Mid-shift, two adjacent slots briefly hold the same entry and the last valid entry has not yet moved down. The bench starts removals near the front of a table that holds repeated addresses, then sweeps `pc_i` over those addresses while `busy_o` is high. Every `pc_type_o` value is compared with a model list that is already compacted. The bench also sends add and remove requests in the same cycle, and sends requests during compaction, to confirm they are dropped.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int ADDR_W = 32;
  localparam int KIND_W = 2;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [KIND_W-1:0] kind;
  } bkpt_t;
endpackage

// File: rtl/bkpt_match.sv
module bkpt_match
  import bkpt_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  bkpt_t [DEPTH-1:0] tbl_i,
  input  logic [CNTW-1:0]   used_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic              use_kind_i,
  output logic              hit_o,
  output logic [IDXW-1:0]   idx_o,
  output logic [KIND_W-1:0] kind_o
);
  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = (CNTW'(g) < used_i) && (tbl_i[g].addr == addr_i) &&
                      (!use_kind_i || (tbl_i[g].kind == kind_i));
  end

  // lowest index wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = IDXW'(i);
      end
    end
  end

  assign kind_o = hit_o ? tbl_i[idx_o].kind : '0;
endmodule

// File: rtl/bkpt_store.sv
module bkpt_store
  import bkpt_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDXW-1:0]   wr_idx_i,
  input  bkpt_t             wr_ent_i,
  input  logic              sh_en_i,
  input  logic [IDXW-1:0]   sh_idx_i,
  output bkpt_t [DEPTH-1:0] tbl_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    bkpt_t nxt;
    if (g < DEPTH - 1) begin : g_mid
      assign nxt = tbl_o[g+1];
    end else begin : g_top
      assign nxt = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tbl_o[g] <= '0;
      end else if (wr_en_i && (wr_idx_i == IDXW'(g))) begin
        tbl_o[g] <= wr_ent_i;
      end else if (sh_en_i && (sh_idx_i == IDXW'(g))) begin
        tbl_o[g] <= nxt;
      end
    end
  end
endmodule

// File: rtl/bkpt_table.sv
module bkpt_table
  import bkpt_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              add_vld_i,
  input  logic [31:0]       add_addr_i,
  input  logic [1:0]        add_type_i,
  input  logic              rem_vld_i,
  input  logic [31:0]       rem_addr_i,
  input  logic [1:0]        rem_type_i,
  output logic              rem_done_o,
  output logic              rem_hit_o,
  input  logic [31:0]       pc_i,
  output logic [1:0]        pc_type_o,
  output logic [CNTW-1:0]   count_o,
  output logic              busy_o,
  output logic              ovf_o,
  output logic              inv_vld_o,
  output logic [31:0]       inv_addr_o
);
  bkpt_t [DEPTH-1:0] tbl;
  logic [CNTW-1:0]   count_q;
  logic              busy_q;
  logic [IDXW-1:0]   ptr_q;

  logic            r_hit, l_hit;
  logic [IDXW-1:0] r_idx, l_idx;
  logic [1:0]      r_kind;

  logic rem_acc, rem_hit_acc, add_acc, add_ok, add_full;
  logic r_last, ptr_last, sh_en;
  logic [IDXW-1:0] sh_idx;

  // remove wins over add; both blocked while compacting
  assign rem_acc     = rem_vld_i && !busy_q;
  assign add_acc     = add_vld_i && !busy_q && !rem_vld_i && (add_type_i != '0);
  assign add_ok      = add_acc && (count_q != CNTW'(DEPTH));
  assign add_full    = add_acc && (count_q == CNTW'(DEPTH));
  assign rem_hit_acc = rem_acc && r_hit;

  assign r_last   = (CNTW'(r_idx) == count_q - 1'b1);
  assign ptr_last = (CNTW'(ptr_q) == count_q - 1'b1);
  assign sh_en    = (rem_hit_acc && !r_last) || (busy_q && !ptr_last);
  assign sh_idx   = busy_q ? ptr_q : r_idx;

  bkpt_match #(.DEPTH(DEPTH)) u_rem_match (
    .tbl_i     (tbl),
    .used_i    (count_q),
    .addr_i    (rem_addr_i),
    .kind_i    (rem_type_i),
    .use_kind_i(1'b1),
    .hit_o     (r_hit),
    .idx_o     (r_idx),
    .kind_o    (r_kind)
  );

  bkpt_match #(.DEPTH(DEPTH)) u_pc_match (
    .tbl_i     (tbl),
    .used_i    (count_q),
    .addr_i    (pc_i),
    .kind_i    (2'b00),
    .use_kind_i(1'b0),
    .hit_o     (l_hit),
    .idx_o     (l_idx),
    .kind_o    (pc_type_o)
  );

  bkpt_store #(.DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (add_ok),
    .wr_idx_i(IDXW'(count_q)),
    .wr_ent_i('{addr: add_addr_i, kind: add_type_i}),
    .sh_en_i (sh_en),
    .sh_idx_i(sh_idx),
    .tbl_o   (tbl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      busy_q  <= 1'b0;
      ptr_q   <= '0;
    end else if (busy_q) begin
      if (ptr_last) begin
        busy_q  <= 1'b0;
        count_q <= count_q - 1'b1;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end else if (rem_hit_acc) begin
      if (r_last) begin
        count_q <= count_q - 1'b1;
      end else begin
        busy_q <= 1'b1;
        ptr_q  <= r_idx + 1'b1;
      end
    end else if (add_ok) begin
      count_q <= count_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_vld_o  <= 1'b0;
      inv_addr_o <= '0;
      rem_done_o <= 1'b0;
      rem_hit_o  <= 1'b0;
      ovf_o      <= 1'b0;
    end else begin
      inv_vld_o  <= add_ok || rem_hit_acc;
      rem_done_o <= rem_acc;
      rem_hit_o  <= rem_hit_acc;
      ovf_o      <= add_full;
      if (rem_hit_acc)  inv_addr_o <= rem_addr_i;
      else if (add_ok)  inv_addr_o <= add_addr_i;
    end
  end

  assign count_o = count_q;
  assign busy_o  = busy_q;

  // R1
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNTW'(DEPTH));

  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (count_q == CNTW'(DEPTH)) && !inv_vld_o);

  // R4
  hit_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_hit_o |-> rem_done_o && inv_vld_o);

  // R6
  count_hold_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> (count_q == $past(count_q)) || !busy_q);

  // R7
  busy_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> !inv_vld_o && !rem_done_o && !ovf_o);

  // R9
  lookup_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0) |-> (pc_type_o == 2'b00));
endmodule

// File: tb/sim_bkpt_table.sv
`timescale 1ns/1ps
module sim_bkpt_table;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        add_vld = 1'b0, rem_vld = 1'b0;
  logic [31:0] add_addr = '0, rem_addr = '0, pc = '0;
  logic [1:0]  add_type = '0, rem_type = '0;
  logic        rem_done, rem_hit, busy, ovf, inv_vld;
  logic [1:0]  pc_type;
  logic [3:0]  count;
  logic [31:0] inv_addr;

  always #4 clk = ~clk;

  bkpt_table #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .add_vld_i(add_vld), .add_addr_i(add_addr), .add_type_i(add_type),
    .rem_vld_i(rem_vld), .rem_addr_i(rem_addr), .rem_type_i(rem_type),
    .rem_done_o(rem_done), .rem_hit_o(rem_hit),
    .pc_i(pc), .pc_type_o(pc_type), .count_o(count), .busy_o(busy),
    .ovf_o(ovf), .inv_vld_o(inv_vld), .inv_addr_o(inv_addr)
  );

  int vectors = 0, errors = 0;
  bit finished = 0;

  // reference model
  logic [31:0] qa[$];
  logic [1:0]  qk[$];
  int          busy_left = 0;
  bit          e_inv = 0, e_done = 0, e_hit = 0, e_ovf = 0;
  logic [31:0] e_inv_addr = '0;

  task automatic chk(string req, string what, longint got, longint exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [1:0] m_lookup(logic [31:0] a);
    for (int i = 0; i < qa.size(); i++) if (qa[i] == a) return qk[i];
    return 2'b00;
  endfunction

  task automatic model_edge(bit av, logic [31:0] aa, logic [1:0] at,
                            bit rv, logic [31:0] ra, logic [1:0] rt);
    e_inv = 0; e_done = 0; e_hit = 0; e_ovf = 0;
    if (busy_left > 0) begin
      busy_left--;
    end else if (rv) begin
      e_done = 1;
      for (int i = 0; i < qa.size(); i++) begin
        if (qa[i] == ra && qk[i] == rt) begin
          int n;
          n = qa.size();
          e_hit = 1; e_inv = 1; e_inv_addr = ra;
          qa.delete(i); qk.delete(i);
          busy_left = n - 1 - i;
          break;
        end
      end
    end else if (av && at != 2'b00) begin
      if (qa.size() == DEPTH) e_ovf = 1;
      else begin
        qa.push_back(aa); qk.push_back(at);
        e_inv = 1; e_inv_addr = aa;
      end
    end
  endtask

  task automatic step(bit av, logic [31:0] aa, logic [1:0] at,
                      bit rv, logic [31:0] ra, logic [1:0] rt,
                      logic [31:0] p, string tag);
    string t;
    add_vld = av; add_addr = aa; add_type = at;
    rem_vld = rv; rem_addr = ra; rem_type = rt; pc = p;
    #1;
    chk("R9", "pc_type", pc_type, m_lookup(p));
    @(posedge clk);
    model_edge(av, aa, at, rv, ra, rt);
    @(negedge clk);
    t = (tag == "") ? "R6" : tag;
    chk(t, "count", count, qa.size() + ((busy_left > 0) ? 1 : 0));
    chk("R6", "busy", busy, (busy_left > 0));
    chk((tag == "") ? "R10" : tag, "inv_vld", inv_vld, e_inv);
    if (e_inv) chk("R10", "inv_addr", inv_addr, e_inv_addr);
    chk((tag == "") ? "R4" : tag, "rem_done", rem_done, e_done);
    chk((tag == "") ? "R5" : tag, "rem_hit", rem_hit, e_hit);
    chk((tag == "") ? "R2" : tag, "ovf", ovf, e_ovf);
  endtask

  task automatic idle(int n, logic [31:0] p);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, p, "");
  endtask

  localparam logic [31:0] B = 32'h8C00_1000;

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "count", count, 0);
    chk("R11", "busy", busy, 0);
    chk("R11", "inv_vld", inv_vld, 0);
    chk("R11", "rem_done", rem_done, 0);
    chk("R11", "rem_hit", rem_hit, 0);
    chk("R11", "ovf", ovf, 0);
    chk("R11", "pc_type", pc_type, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 appends, with a repeated address
    step(1, B+0, 1, 0, 0, 0, B, "R1");
    step(1, B+2, 2, 0, 0, 0, B+2, "R1");
    step(1, B+4, 3, 0, 0, 0, B+4, "R1");
    step(1, B+2, 1, 0, 0, 0, B+2, "R1");
    step(1, B+6, 2, 0, 0, 0, B+2, "R1");
    // R3 kind 0 ignored
    step(1, B+8, 0, 0, 0, 0, B+8, "R3");
    idle(1, B+8);
    // R4 remove second copy of B+2 (index 3 of 5)
    step(0, 0, 0, 1, B+2, 1, B+2, "R4");
    idle(2, B+6);
    // remove front entry: 3 cycles of compaction, R7 requests during busy
    step(0, 0, 0, 1, B+0, 1, B+6, "R4");
    step(1, B+10, 3, 0, 0, 0, B+4, "R7");
    step(0, 0, 0, 1, B+4, 3, B+6, "R7");
    step(0, 0, 0, 0, 0, 0, B+2, "R6");
    idle(1, B+6);
    // R5 miss: wrong kind
    step(0, 0, 0, 1, B+4, 1, B+4, "R5");
    idle(1, B+4);
    // R8 add and remove together
    step(1, B+12, 1, 1, B+6, 2, B+12, "R8");
    idle(1, B+12);
    // fill and overflow (R2)
    for (int i = 0; i < 8; i++) step(1, B + 32'(16 + 2*i), 2'(1 + i % 3), 0, 0, 0, B+16, "R1");
    step(1, B+40, 1, 0, 0, 0, B+40, "R2");
    idle(1, B+40);
    // remove last entry: no busy
    step(0, 0, 0, 1, qa[qa.size()-1], qk[qk.size()-1], B, "R6");
    idle(1, B);

    // random traffic over a small address pool
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a1, a2, p;
      a1 = B + 32'(2 * ($urandom % 6));
      a2 = B + 32'(2 * ($urandom % 6));
      p  = B + 32'(2 * ($urandom % 7));
      step(($urandom % 3) == 0, a1, 2'($urandom), ($urandom % 4) == 0, a2, 2'($urandom), p, "");
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      vectors++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule